// File: doc/BRIEF.md
# Binary Point Group Priority Masker

This block keeps the binary point settings of an interrupt controller's CPU side: one for group 0, a secure and a non-secure copy for group 1, and a virtual pair for group 0 and group 1. Each setting decides how many of the upper bits of an 8-bit interrupt priority form the group (preemption) priority. The remaining lower bits are the subpriority.

Software writes a setting by naming a target group. For group 1, the security state picks the bank. The block clamps each write to that register's floor. On the query side, a group select and an 8-bit priority come in. The block returns the group-priority mask and the masked priority in the same cycle, so a preemption decision can use them directly.

The non-secure group-1 setting and the virtual group-1 setting are encoded one step higher than the others. The block takes one off before it builds their mask. When no EL3 is present, all group-1 traffic goes to the non-secure copy.

Top module: `bpm_masker`

## Requirements
- R1: After reset the stored values are: group 0 = 0, secure group 1 = 0, non-secure group 1 = 1, virtual group 0 = VMIN_G0 (default 2), virtual group 1 = VMIN_G0 + 1 (default 3).
- R2: With `wr_en` high, a write stores `wr_data` in the target selected by `wr_grp`, where 0 = group 0, 1 = group 1, 2 = virtual group 0 and 3 = virtual group 1. The new value reads back from the next cycle on.
- R3: A write below a register's floor stores the floor instead. The floors are 0 for group 0, 0 for secure group 1, 1 for non-secure group 1, VMIN_G0 for virtual group 0 and VMIN_G0 + 1 for virtual group 1.
- R4: A group-1 write lands in the secure copy only when `el3_present` and `secure` are both high. Otherwise it lands in the non-secure copy. The copy that is not selected keeps its value.
- R5: Group 0 uses its stored value n directly. A group-1 query with both `el3_present` and `secure` high uses the secure copy's value n directly. In these cases `gp_mask` bit b is 1 exactly when b > n, so 0 gives 8'hFE and 7 gives 8'h00.
- R6: A group-1 query with `el3_present` low or `secure` low uses the non-secure copy with n = stored value − 1. A stored 1 therefore gives 8'hFE.
- R7: A virtual group-0 query (`q_grp` = 2) uses n = stored value. A virtual group-1 query (`q_grp` = 3) uses n = stored value − 1.
- R8: `gp_prio` equals `q_prio` with every bit cleared where `gp_mask` is 0.
- R9: While `wr_en` is low, none of the five stored values changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_grp | input | 2 | Write target: 0 group 0, 1 group 1, 2 virtual group 0, 3 virtual group 1 |
| wr_data | input | BP_W (3) | Binary point value to write |
| secure | input | 1 | Current security state, 1 = secure |
| el3_present | input | 1 | Configuration strap, 1 = both security banks exist |
| q_grp | input | 2 | Query group, same encoding as `wr_grp` |
| q_prio | input | PRIO_W (8) | Priority to mask |
| rd_g0 | output | BP_W | Group 0 stored value |
| rd_g1s | output | BP_W | Secure group 1 stored value |
| rd_g1ns | output | BP_W | Non-secure group 1 stored value |
| rd_vg0 | output | BP_W | Virtual group 0 stored value |
| rd_vg1 | output | BP_W | Virtual group 1 stored value |
| gp_mask | output | PRIO_W | Group-priority mask for the query |
| gp_prio | output | PRIO_W | Masked priority |

## Verification
The assertions assume every input is a known value from the first clock after reset. Every `wr_grp` and `q_grp` code is legal, so no input code can be ill-formed.

The strap `el3_present` is treated as a level that is sampled each cycle. The write-routing property reads it in the same cycle as the write. The stimulus changes all inputs shortly after a rising edge, so they are settled around the next edge.

The stimulus sweeps every group, both strap settings, both security states and every binary point value, including values under each floor.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

   typedef enum logic [1:0] {
      GRP_G0  = 2'd0,
      GRP_G1  = 2'd1,
      GRP_VG0 = 2'd2,
      GRP_VG1 = 2'd3
   } grp_e;

   // storage slot index, also the order of the floor table in the top
   typedef enum logic [2:0] {
      SRC_G0   = 3'd0,
      SRC_G1S  = 3'd1,
      SRC_G1NS = 3'd2,
      SRC_VG0  = 3'd3,
      SRC_VG1  = 3'd4
   } src_e;

   localparam int NREG = 5;

endpackage

// File: rtl/bpm_bp_reg.sv
module bpm_bp_reg #(
   parameter int BP_W    = 3,
   parameter int MIN_VAL = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [BP_W-1:0] wdata,
   output logic [BP_W-1:0] q
);
   localparam logic [BP_W-1:0] FLOOR = BP_W'(MIN_VAL);

   logic [BP_W-1:0] nxt;

   generate
      if (MIN_VAL == 0) begin : g_no_floor
         assign nxt = wdata;
      end else begin : g_floor
         assign nxt = (wdata < FLOOR) ? FLOOR : wdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= FLOOR;
      end else if (we) begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/bpm_route.sv
module bpm_route
   import bpm_pkg::*;
(
   input  logic            wr_en,
   input  logic [1:0]      wr_grp,
   input  logic            secure,
   input  logic            el3_present,
   input  logic [1:0]      q_grp,
   output logic [NREG-1:0] we,
   output src_e            q_src,
   output logic            q_off
);
   logic use_sec;
   src_e w_src;

   assign use_sec = el3_present & secure;

   function automatic src_e pick(input logic [1:0] g, input logic s);
      case (grp_e'(g))
         GRP_G0:  pick = SRC_G0;
         GRP_G1:  pick = s ? SRC_G1S : SRC_G1NS;
         GRP_VG0: pick = SRC_VG0;
         default: pick = SRC_VG1;
      endcase
   endfunction

   assign w_src = pick(wr_grp, use_sec);
   assign q_src = pick(q_grp, use_sec);
   assign q_off = (q_src == SRC_G1NS) || (q_src == SRC_VG1);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_we
         assign we[i] = wr_en && (w_src == src_e'(i));
      end
   endgenerate
endmodule

// File: rtl/bpm_mask_gen.sv
module bpm_mask_gen #(
   parameter int PRIO_W = 8,
   parameter int BP_W   = 3
) (
   input  logic [BP_W-1:0]   bp,
   input  logic              off,
   input  logic [PRIO_W-1:0] prio,
   output logic [PRIO_W-1:0] mask,
   output logic [PRIO_W-1:0] gp
);
   logic [BP_W-1:0] eff;

   assign eff = (off && (bp != '0)) ? (bp - BP_W'(1)) : bp;

   generate
      for (genvar b = 0; b < PRIO_W; b++) begin : g_bit
         localparam logic [BP_W-1:0] BIDX = BP_W'(b);
         assign mask[b] = (BIDX > eff);
         assign gp[b]   = prio[b] & mask[b];
      end
   endgenerate
endmodule

// File: rtl/bpm_masker.sv
module bpm_masker
   import bpm_pkg::*;
#(
   parameter int PRIO_W   = 8,
   parameter int BP_W     = 3,
   parameter int MIN_SEC  = 0,
   parameter int MIN_NSEC = 1,
   parameter int VMIN_G0  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_grp,
   input  logic [BP_W-1:0]   wr_data,
   input  logic              secure,
   input  logic              el3_present,
   input  logic [1:0]        q_grp,
   input  logic [PRIO_W-1:0] q_prio,
   output logic [BP_W-1:0]   rd_g0,
   output logic [BP_W-1:0]   rd_g1s,
   output logic [BP_W-1:0]   rd_g1ns,
   output logic [BP_W-1:0]   rd_vg0,
   output logic [BP_W-1:0]   rd_vg1,
   output logic [PRIO_W-1:0] gp_mask,
   output logic [PRIO_W-1:0] gp_prio
);
   localparam int BP_MAX = (1 << BP_W) - 1;
   localparam int FLOOR_TAB [NREG] = '{MIN_SEC, MIN_SEC, MIN_NSEC, VMIN_G0, VMIN_G0 + 1};

   generate
      if ((1 << BP_W) != PRIO_W) begin : g_bad_width
         initial $fatal(1, "bpm_masker: PRIO_W must equal 2**BP_W");
      end
      if (MIN_NSEC < 1 || MIN_SEC < 0 || VMIN_G0 < 0) begin : g_bad_floor
         initial $fatal(1, "bpm_masker: offset floors must be at least 1");
      end
      if (VMIN_G0 + 1 > BP_MAX || MIN_NSEC > BP_MAX) begin : g_bad_range
         initial $fatal(1, "bpm_masker: floor exceeds field range");
      end
   endgenerate

   logic [NREG-1:0] we;
   src_e            q_src;
   logic            q_off;
   logic [BP_W-1:0] bp_q [NREG];

   bpm_route u_route (
      .wr_en       (wr_en),
      .wr_grp      (wr_grp),
      .secure      (secure),
      .el3_present (el3_present),
      .q_grp       (q_grp),
      .we          (we),
      .q_src       (q_src),
      .q_off       (q_off)
   );

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         bpm_bp_reg #(
            .BP_W    (BP_W),
            .MIN_VAL (FLOOR_TAB[i])
         ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[i]),
            .wdata (wr_data),
            .q     (bp_q[i])
         );
      end
   endgenerate

   assign rd_g0   = bp_q[SRC_G0];
   assign rd_g1s  = bp_q[SRC_G1S];
   assign rd_g1ns = bp_q[SRC_G1NS];
   assign rd_vg0  = bp_q[SRC_VG0];
   assign rd_vg1  = bp_q[SRC_VG1];

   bpm_mask_gen #(
      .PRIO_W (PRIO_W),
      .BP_W   (BP_W)
   ) u_mask (
      .bp   (bp_q[q_src]),
      .off  (q_off),
      .prio (q_prio),
      .mask (gp_mask),
      .gp   (gp_prio)
   );
endmodule

// File: rtl/bpm_masker_chk.sv
module bpm_masker_chk #(
   parameter int PRIO_W   = 8,
   parameter int BP_W     = 3,
   parameter int MIN_SEC  = 0,
   parameter int MIN_NSEC = 1,
   parameter int VMIN_G0  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_grp,
   input logic [BP_W-1:0]   wr_data,
   input logic              secure,
   input logic              el3_present,
   input logic [BP_W-1:0]   rd_g0,
   input logic [BP_W-1:0]   rd_g1s,
   input logic [BP_W-1:0]   rd_g1ns,
   input logic [BP_W-1:0]   rd_vg0,
   input logic [BP_W-1:0]   rd_vg1,
   input logic [PRIO_W-1:0] gp_mask,
   input logic [PRIO_W-1:0] gp_prio
);
   localparam logic [BP_W-1:0] F_S   = BP_W'(MIN_SEC);
   localparam logic [BP_W-1:0] F_NS  = BP_W'(MIN_NSEC);
   localparam logic [BP_W-1:0] F_V0  = BP_W'(VMIN_G0);
   localparam logic [BP_W-1:0] F_V1  = BP_W'(VMIN_G0 + 1);

   logic [PRIO_W-1:0] inv_mask;
   assign inv_mask = ~gp_mask;

   // R3: stored values never sit below their floors
   p_ns_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_g1ns >= F_NS);
   p_v_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vg0 >= F_V0) && (rd_vg1 >= F_V1));

   // R2: a group-0 write is visible on the next cycle
   p_g0_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_grp == 2'd0) |=>
         rd_g0 == (($past(wr_data) < F_S) ? F_S : $past(wr_data)));

   // R9: no strobe, no change
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({rd_g0, rd_g1s, rd_g1ns, rd_vg0, rd_vg1}));

   // R4: the secure copy is untouched by a non-secure-routed group-1 write
   p_sec_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_grp == 2'd1 && !(el3_present && secure)) |=> $stable(rd_g1s));

   // R5: the mask is a run of ones from the top with bit 0 always clear
   p_mask_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !gp_mask[0] && ((inv_mask & (inv_mask + PRIO_W'(1))) == '0));

   // R8: no bit outside the mask leaks to the output
   p_no_leak_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gp_prio & inv_mask) == '0);
endmodule

bind bpm_masker bpm_masker_chk #(
   .PRIO_W   (PRIO_W),
   .BP_W     (BP_W),
   .MIN_SEC  (MIN_SEC),
   .MIN_NSEC (MIN_NSEC),
   .VMIN_G0  (VMIN_G0)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_grp      (wr_grp),
   .wr_data     (wr_data),
   .secure      (secure),
   .el3_present (el3_present),
   .rd_g0       (rd_g0),
   .rd_g1s      (rd_g1s),
   .rd_g1ns     (rd_g1ns),
   .rd_vg0      (rd_vg0),
   .rd_vg1      (rd_vg1),
   .gp_mask     (gp_mask),
   .gp_prio     (gp_prio)
);

// File: tb/bpm_masker_tb_top.sv
`timescale 1ns/1ps
module bpm_masker_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_grp = 2'd0;
   logic [2:0] wr_data = 3'd0;
   logic       secure = 1'b0;
   logic       el3_present = 1'b1;
   logic [1:0] q_grp = 2'd0;
   logic [7:0] q_prio = 8'h00;
   logic [2:0] rd_g0, rd_g1s, rd_g1ns, rd_vg0, rd_vg1;
   logic [7:0] gp_mask, gp_prio;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference state, slot order: g0, g1 secure, g1 non-secure, v0, v1
   int ref_bp [5];
   int floor_v [5] = '{0, 0, 1, 2, 3};

   always #5 clk = ~clk;

   bpm_masker dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_grp (wr_grp),
      .wr_data (wr_data), .secure (secure), .el3_present (el3_present),
      .q_grp (q_grp), .q_prio (q_prio),
      .rd_g0 (rd_g0), .rd_g1s (rd_g1s), .rd_g1ns (rd_g1ns),
      .rd_vg0 (rd_vg0), .rd_vg1 (rd_vg1),
      .gp_mask (gp_mask), .gp_prio (gp_prio)
   );

   function automatic int slot_of(input int g, input bit s, input bit e);
      if (g == 0) return 0;
      if (g == 1) return (s && e) ? 1 : 2;
      if (g == 2) return 3;
      return 4;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 5; k++) ref_bp[k] <= floor_v[k];
      end else if (wr_en) begin
         int t;
         int d;
         t = slot_of(int'(wr_grp), secure, el3_present);
         d = int'(wr_data);
         ref_bp[t] <= (d < floor_v[t]) ? floor_v[t] : d;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int s;
         int n;
         int m;
         string mreq;
         s = slot_of(int'(q_grp), secure, el3_present);
         n = ref_bp[s] - ((s == 2 || s == 4) ? 1 : 0);
         m = 0;
         for (int b = 0; b < 8; b++) if (b > n) m |= (1 << b);
         if (s == 0 || s == 1) mreq = "R5";
         else if (s == 2) mreq = "R6";
         else mreq = "R7";
         check(cur_req, "rd_g0",   int'(rd_g0),   ref_bp[0]);
         check(cur_req, "rd_g1s",  int'(rd_g1s),  ref_bp[1]);
         check(cur_req, "rd_g1ns", int'(rd_g1ns), ref_bp[2]);
         check(cur_req, "rd_vg0",  int'(rd_vg0),  ref_bp[3]);
         check(cur_req, "rd_vg1",  int'(rd_vg1),  ref_bp[4]);
         check(mreq, "gp_mask", int'(gp_mask), m);
         check("R8", "gp_prio", int'(gp_prio), int'(q_prio) & m);
      end
   end

   task automatic step(input bit we, input int g, input int d, input bit s,
                       input bit e, input int qg, input int qp);
      @(posedge clk);
      #2;
      wr_en = we; wr_grp = 2'(g); wr_data = 3'(d);
      secure = s; el3_present = e; q_grp = 2'(qg); q_prio = 8'(qp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=50000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset values seen through reads and masks
      cur_req = "R1";
      step(0, 0, 0, 0, 1, 0, 'hFF);
      step(0, 0, 0, 0, 1, 1, 'hFF);
      step(0, 0, 0, 1, 1, 1, 'hA5);
      step(0, 0, 0, 0, 1, 3, 'h5A);
      // R2 plain writes
      cur_req = "R2";
      step(1, 0, 5, 0, 1, 0, 'hFF);
      step(1, 0, 3, 0, 1, 0, 'hC3);
      step(1, 3, 6, 0, 1, 3, 'hFF);
      // R9 strobe low with busy data
      cur_req = "R9";
      for (int k = 0; k < 8; k++) step(0, k % 4, 7 - k, k[0], k[1], k % 4, 'h3C);
      // R4 group-1 routing
      cur_req = "R4";
      step(1, 1, 4, 1, 1, 1, 'hFF);
      step(1, 1, 6, 0, 1, 1, 'hFF);
      step(1, 1, 2, 1, 0, 1, 'hFF);
      step(0, 0, 0, 1, 1, 1, 'hFF);
      // R3 clamping
      cur_req = "R3";
      step(1, 1, 0, 0, 1, 1, 'hFF);
      step(1, 2, 0, 0, 1, 2, 'hFF);
      step(1, 2, 1, 0, 1, 2, 'hFF);
      step(1, 3, 2, 0, 1, 3, 'hFF);
      step(1, 3, 0, 0, 1, 3, 'hFF);
      step(1, 0, 0, 1, 1, 0, 'hFF);
      step(1, 1, 0, 1, 1, 1, 'hFF);
      // R5 R6 R7 R8 full sweep
      cur_req = "R5";
      for (int g = 0; g < 4; g++)
         for (int e = 0; e < 2; e++)
            for (int s = 0; s < 2; s++)
               for (int v = 0; v < 8; v++)
                  for (int p = 0; p < 3; p++)
                     step(1, g, v, s[0], e[0], g, (p == 0) ? 'hFF : (p == 1) ? 'hA5 : 'h5A);
      step(0, 0, 0, 0, 1, 0, 'h00);
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule